// File: doc/BRIEF.md
# Reversal-Sharing Shift and Rotate Unit

This block is a purely combinational 32-bit bit-manipulation datapath. It performs logical shifts in both directions, ones-filling shifts in both directions, rotates in both directions, full bit reversal, byte-order swap and a per-byte OR-combine. All shifting goes through one right shifter.

A left operation is handled in three steps: the operand is bit-reversed, shifted right, and the result is reversed back. The right shifter works on a double-width word. Its upper half holds zeros for logical shifts, ones for ones-filling shifts, and a second copy of the operand for rotates. The result is the low half of the shifted word.

A full bit reversal reuses the input reverser with the shift amount forced to zero. The byte swap and the OR-combine come from a small per-byte network beside the shifter. An execution stage drives the operand, the amount and an operation code, and takes the result in the same cycle.

Top module: `shrot_unit`

## Requirements
- R1: The operation code `op_i` is 4 bits wide, with these values: 0 SRL, 1 SLL, 2 SRO, 3 SLO, 4 ROR, 5 ROL, 6 REV, 7 REV8, 8 ORCB. Codes 9 to 15 give a result of all zeros.
- R2: SRL shifts the operand right by the amount and fills the vacated upper bits with zeros.
- R3: SLL shifts the operand left by the amount and fills the vacated lower bits with zeros.
- R4: SRO shifts the operand right and fills the vacated upper bits with ones.
- R5: SLO shifts the operand left and fills the vacated lower bits with ones.
- R6: ROR rotates right: bit i of the result is operand bit (i+n) mod 32.
- R7: ROL rotates left: bit i of the result is operand bit (i-n) mod 32.
- R8: REV returns the operand bit-reversed: result bit i is operand bit 31-i.
- R9: REV8 swaps the byte order: result byte k is operand byte 3-k.
- R10: In ORCB, each result byte is 0xFF if any bit of the matching operand byte is set, and 0x00 otherwise.
- R11: Only bits [4:0] of the 8-bit `amt_i` are used. Bits [7:5] have no effect on any result.
- R12: An effective amount of zero returns the operand unchanged for all six shift and rotate operations.
- R13: REV, REV8 and ORCB ignore `amt_i` entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand |
| amt_i | input | 8 | Shift or rotate amount; only bits [4:0] are used |
| op_i | input | 4 | Operation code (see R1) |
| res_o | output | 32 | Result |

## Verification
ROL and REV both pass through the same input reverser in a single evaluation. The difference between them is whether the output reverser is applied and whether the amount is forced to zero. The bench therefore switches between ROL and REV on the same operand and a non-zero amount, with nothing else changing, and checks each result against its own bit-loop model. A leaked output reversal or a leaked amount shows up as a mismatch. The same method pairs SLO with SRO at amount zero, where the two reversals must cancel and the result must equal the operand.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
   typedef enum logic [3:0] {
      OP_SRL  = 4'd0,
      OP_SLL  = 4'd1,
      OP_SRO  = 4'd2,
      OP_SLO  = 4'd3,
      OP_ROR  = 4'd4,
      OP_ROL  = 4'd5,
      OP_REV  = 4'd6,
      OP_REV8 = 4'd7,
      OP_ORCB = 4'd8
   } shrot_op_e;

   typedef enum logic [1:0] {
      SEL_SHIFT = 2'd0,
      SEL_REV8  = 2'd1,
      SEL_ORCB  = 2'd2,
      SEL_ZERO  = 2'd3
   } shrot_sel_e;
endpackage

// File: rtl/shrot_bitrev.sv
module shrot_bitrev #(
   parameter int WIDTH = 32
) (
   input  logic             en_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] flipped;

   for (genvar b = 0; b < WIDTH; b++) begin : g_flip
      assign flipped[b] = d_i[WIDTH-1-b];
   end

   assign q_o = en_i ? flipped : d_i;
endmodule

// File: rtl/shrot_funnel.sv
module shrot_funnel #(
   parameter int WIDTH = 32,
   localparam int AMT_W = $clog2(WIDTH),
   localparam int DBL_W = 2 * WIDTH
) (
   input  logic [WIDTH-1:0] hi_i,
   input  logic [WIDTH-1:0] lo_i,
   input  logic [AMT_W-1:0] amt_i,
   output logic [WIDTH-1:0] q_o
);
   logic [DBL_W-1:0] stage [AMT_W+1];

   assign stage[0] = {hi_i, lo_i};

   for (genvar s = 0; s < AMT_W; s++) begin : g_stage
      localparam int STEP = 1 << s;
      assign stage[s+1] = amt_i[s] ? (stage[s] >> STEP) : stage[s];
   end

   logic [WIDTH-1:0] unused_top;
   assign unused_top = stage[AMT_W][DBL_W-1:WIDTH];
   assign q_o        = stage[AMT_W][WIDTH-1:0];
endmodule

// File: rtl/shrot_bytenet.sv
module shrot_bytenet #(
   parameter int WIDTH = 32,
   localparam int NB = WIDTH / 8
) (
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] swap_o,
   output logic [WIDTH-1:0] orc_o
);
   for (genvar k = 0; k < NB; k++) begin : g_byte
      assign swap_o[8*k +: 8] = d_i[8*(NB-1-k) +: 8];
      assign orc_o[8*k +: 8]  = {8{|d_i[8*k +: 8]}};
   end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
   parameter int WIDTH      = 32,
   parameter int AMT_PORT_W = 8,
   localparam int AMT_W     = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0]      opnd_i,
   input  logic [AMT_PORT_W-1:0] amt_i,
   input  logic [3:0]            op_i,
   output logic [WIDTH-1:0]      res_o
);
   import shrot_pkg::*;

   if ((WIDTH < 8) || (WIDTH % 8 != 0) || ((WIDTH & (WIDTH - 1)) != 0)) begin : g_bad_width
      $error("shrot_unit: WIDTH must be a power of two and at least 8");
   end
   if (AMT_PORT_W < AMT_W) begin : g_bad_amt
      $error("shrot_unit: AMT_PORT_W is narrower than log2(WIDTH)");
   end

   if (AMT_PORT_W > AMT_W) begin : g_amt_spare
      logic unused_amt_hi;
      assign unused_amt_hi = ^amt_i[AMT_PORT_W-1:AMT_W];
   end

   logic             rev_in, rev_out, fill_ones, rotate, amt_kill;
   shrot_sel_e       sel;
   logic [AMT_W-1:0] amt_eff;
   logic [WIDTH-1:0] opnd_oriented, upper_half, shifted, shift_res;
   logic [WIDTH-1:0] swap_res, orc_res;

   always_comb begin
      rev_in    = 1'b0;
      rev_out   = 1'b0;
      fill_ones = 1'b0;
      rotate    = 1'b0;
      amt_kill  = 1'b0;
      sel       = SEL_SHIFT;
      case (op_i)
         OP_SRL:  ;
         OP_SLL:  begin rev_in = 1'b1; rev_out = 1'b1; end
         OP_SRO:  fill_ones = 1'b1;
         OP_SLO:  begin rev_in = 1'b1; rev_out = 1'b1; fill_ones = 1'b1; end
         OP_ROR:  rotate = 1'b1;
         OP_ROL:  begin rev_in = 1'b1; rev_out = 1'b1; rotate = 1'b1; end
         OP_REV:  begin rev_in = 1'b1; amt_kill = 1'b1; end
         OP_REV8: sel = SEL_REV8;
         OP_ORCB: sel = SEL_ORCB;
         default: sel = SEL_ZERO;
      endcase
   end

   assign amt_eff = amt_kill ? '0 : amt_i[AMT_W-1:0];

   shrot_bitrev #(.WIDTH(WIDTH)) i_rev_in (
      .en_i (rev_in),
      .d_i  (opnd_i),
      .q_o  (opnd_oriented)
   );

   always_comb begin
      if (rotate)         upper_half = opnd_oriented;
      else if (fill_ones) upper_half = '1;
      else                upper_half = '0;
   end

   shrot_funnel #(.WIDTH(WIDTH)) i_funnel (
      .hi_i  (upper_half),
      .lo_i  (opnd_oriented),
      .amt_i (amt_eff),
      .q_o   (shifted)
   );

   shrot_bitrev #(.WIDTH(WIDTH)) i_rev_out (
      .en_i (rev_out),
      .d_i  (shifted),
      .q_o  (shift_res)
   );

   shrot_bytenet #(.WIDTH(WIDTH)) i_bytes (
      .d_i    (opnd_i),
      .swap_o (swap_res),
      .orc_o  (orc_res)
   );

   always_comb begin
      unique case (sel)
         SEL_SHIFT: res_o = shift_res;
         SEL_REV8:  res_o = swap_res;
         SEL_ORCB:  res_o = orc_res;
         default:   res_o = '0;
      endcase
   end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
   parameter int WIDTH      = 32,
   parameter int AMT_PORT_W = 8,
   localparam int AMT_W     = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0]      opnd_i,
   input logic [AMT_PORT_W-1:0] amt_i,
   input logic [3:0]            op_i,
   input logic [WIDTH-1:0]      res_o
);
   logic [AMT_W-1:0] n;
   logic [WIDTH-1:0] keep_mask;
   logic             is_shift_op;

   always_comb begin
      n           = amt_i[AMT_W-1:0];
      keep_mask   = {WIDTH{1'b1}} >> n;
      is_shift_op = (op_i <= 4'd5);

      // R2: vacated upper bits of SRL are zero
      p_srl_zero_fill_r2: assert (op_i != 4'd0 || (res_o & ~keep_mask) == '0)
         else $error("SRL upper fill not zero");

      // R4: vacated upper bits of SRO are one
      p_sro_ones_fill_r4: assert (op_i != 4'd2 || (res_o | keep_mask) == '1)
         else $error("SRO upper fill not ones");

      // R6 and R7: a rotate keeps the population count
      p_rot_popcount_r6: assert (!(op_i == 4'd4 || op_i == 4'd5) ||
                                 $countones(res_o) == $countones(opnd_i))
         else $error("rotate changed population count");

      // R12: zero amount leaves the operand unchanged
      p_zero_amt_identity_r12: assert (!(is_shift_op && n == '0) || res_o == opnd_i)
         else $error("zero amount altered operand");

      // R1: undefined codes give zero
      p_bad_op_zero_r1: assert (op_i <= 4'd8 || res_o == '0)
         else $error("undefined op gave non-zero");

      for (int i = 0; i < WIDTH; i++) begin
         // R8: mirrored bits
         p_rev_mirror_r8: assert (op_i != 4'd6 || res_o[i] == opnd_i[WIDTH-1-i])
            else $error("REV bit %0d wrong", i);
      end

      for (int k = 0; k < WIDTH / 8; k++) begin
         // R10: each ORCB byte is all ones or all zeros, matching the source byte
         p_orcb_byte_r10: assert (op_i != 4'd8 ||
            res_o[8*k +: 8] == (opnd_i[8*k +: 8] != 8'h00 ? 8'hFF : 8'h00))
            else $error("ORCB byte %0d wrong", k);
         // R9: bytes swapped end for end
         p_rev8_swap_r9: assert (op_i != 4'd7 ||
            res_o[8*k +: 8] == opnd_i[8*(WIDTH/8-1-k) +: 8])
            else $error("REV8 byte %0d wrong", k);
      end
   end
endmodule

bind shrot_unit shrot_unit_chk #(.WIDTH(WIDTH), .AMT_PORT_W(AMT_PORT_W)) i_chk (
   .opnd_i (opnd_i),
   .amt_i  (amt_i),
   .op_i   (op_i),
   .res_o  (res_o)
);

// File: tb/test_shrot_unit.sv
module test_shrot_unit;
   logic        clk = 1'b0;
   logic [31:0] opnd;
   logic [7:0]  amt;
   logic [3:0]  op;
   logic [31:0] res;
   int          n_checks = 0;
   int          n_fail   = 0;
   logic        done     = 1'b0;

   always #4 clk = ~clk;

   shrot_unit i_shrot_unit (
      .opnd_i (opnd),
      .amt_i  (amt),
      .op_i   (op),
      .res_o  (res)
   );

   function automatic logic [31:0] m_srl(logic [31:0] a, int s, logic fill);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = (i + s < 32) ? a[i+s] : fill;
      return r;
   endfunction
   function automatic logic [31:0] m_sll(logic [31:0] a, int s, logic fill);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = (i >= s) ? a[i-s] : fill;
      return r;
   endfunction
   function automatic logic [31:0] m_ror(logic [31:0] a, int s);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = a[(i + s) % 32];
      return r;
   endfunction
   function automatic logic [31:0] m_rol(logic [31:0] a, int s);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = a[(i - s + 32) % 32];
      return r;
   endfunction
   function automatic logic [31:0] m_rev(logic [31:0] a);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = a[31-i];
      return r;
   endfunction
   function automatic logic [31:0] m_orc(logic [31:0] a);
      logic [31:0] r;
      for (int k = 0; k < 4; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
      return r;
   endfunction

   task automatic check(string req, logic [31:0] exp);
      n_checks++;
      if (res !== exp) begin
         n_fail++;
         $display("FAIL %s op=%0d amt=%0d opnd=%h got=%h exp=%h", req, op, amt, opnd, res, exp);
      end
   endtask

   task automatic apply(logic [3:0] o, logic [31:0] a, logic [7:0] s);
      @(negedge clk);
      op = o; opnd = a; amt = s;
      #1;
   endtask

   logic [31:0] pats [4] = '{32'hDEADBEEF, 32'h80000001, 32'h00F0_0F00, 32'h1234_5678};
   int          amts [4] = '{1, 7, 16, 31};

   task automatic t_idle();
      apply(4'd0, 32'h0, 8'd0);
      check("R1 idle", 32'h0);
   endtask

   task automatic t_shifts();
      foreach (pats[p]) foreach (amts[q]) begin
         apply(4'd0, pats[p], 8'(amts[q])); check("R2 srl", m_srl(pats[p], amts[q], 1'b0));
         apply(4'd1, pats[p], 8'(amts[q])); check("R3 sll", m_sll(pats[p], amts[q], 1'b0));
         apply(4'd2, pats[p], 8'(amts[q])); check("R4 sro", m_srl(pats[p], amts[q], 1'b1));
         apply(4'd3, pats[p], 8'(amts[q])); check("R5 slo", m_sll(pats[p], amts[q], 1'b1));
      end
   endtask

   task automatic t_rotates();
      foreach (pats[p]) foreach (amts[q]) begin
         apply(4'd4, pats[p], 8'(amts[q])); check("R6 ror", m_ror(pats[p], amts[q]));
         apply(4'd5, pats[p], 8'(amts[q])); check("R7 rol", m_rol(pats[p], amts[q]));
      end
   endtask

   task automatic t_bytes_rev();
      foreach (pats[p]) begin
         apply(4'd6, pats[p], 8'd0);
         check("R8 rev", m_rev(pats[p]));
         apply(4'd7, pats[p], 8'd0);
         check("R9 rev8", {pats[p][7:0], pats[p][15:8], pats[p][23:16], pats[p][31:24]});
         apply(4'd8, pats[p], 8'd0);
         check("R10 orcb", m_orc(pats[p]));
      end
      apply(4'd8, 32'h0100_0080, 8'd0); check("R10 orcb edge", 32'hFF00_00FF);
   endtask

   task automatic t_amt_upper();
      for (int o = 0; o < 6; o++) begin
         apply(4'(o), 32'hC3A5_0F96, 8'd3);
         begin
            logic [31:0] ref_v = res;
            apply(4'(o), 32'hC3A5_0F96, 8'hE3);
            check("R11 upper amt bits", ref_v);
         end
      end
      apply(4'd2, 32'h8000_0000, 8'd32); check("R11 amt 32 acts as 0", 32'h8000_0000);
   endtask

   task automatic t_zero_amt();
      for (int o = 0; o < 6; o++) begin
         apply(4'(o), 32'h9ABC_DEF0, 8'd0);
         check("R12 zero amount", 32'h9ABC_DEF0);
      end
   endtask

   task automatic t_amt_ignored();
      apply(4'd6, 32'h0000_00F1, 8'd13); check("R13 rev amt", m_rev(32'h0000_00F1));
      apply(4'd7, 32'hAABB_CCDD, 8'd9);  check("R13 rev8 amt", 32'hDDCC_BBAA);
      apply(4'd8, 32'h0010_0000, 8'd255); check("R13 orcb amt", 32'h00FF_0000);
   endtask

   task automatic t_bad_ops();
      for (int o = 9; o < 16; o++) begin
         apply(4'(o), 32'hFFFF_FFFF, 8'd5);
         check("R1 undefined code", 32'h0);
      end
   endtask

   task automatic t_shared_path();
      for (int k = 0; k < 3; k++) begin
         apply(4'd5, 32'h0000_000F, 8'd4); check("R7 rol shared", 32'h0000_00F0);
         apply(4'd6, 32'h0000_000F, 8'd4); check("R8 rev shared", 32'hF000_0000);
      end
      apply(4'd3, 32'h1357_9BDF, 8'd0); check("R12 slo zero", 32'h1357_9BDF);
      apply(4'd2, 32'h1357_9BDF, 8'd0); check("R12 sro zero", 32'h1357_9BDF);
   endtask

   initial begin
      op = 4'd0; opnd = '0; amt = '0;
      t_idle();
      t_shifts();
      t_rotates();
      t_bytes_rev();
      t_amt_upper();
      t_zero_amt();
      t_amt_ignored();
      t_bad_ops();
      t_shared_path();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule